// File: doc/BRIEF.md
# Maskable Alarm Interrupt Register

This block gathers four single-cycle timing-error events into sticky status flags and raises an active-high interrupt request towards a host processor. The four events are a parallel-port clock error, a receive alignment alarm, a transmit alignment alarm and a frame-sync alarm. Each event has its own mask bit. A masked event is still recorded in its status flag, but it is kept off the interrupt line.

The status flags and the mask bits share one 8-bit register. The host reads this register through a plain read port. Any host write to the register, whatever the data, clears every status flag and the interrupt, and loads the four mask bits from the written byte. The interrupt output is registered and follows the register contents.

Top module: `alarm_irq_reg`

## Requirements
- R1: After synchronous reset `rd_data` reads 8'hF0 (all flags clear, all four masks set) and `irq` is low.
- R2: A one-cycle pulse on `ev_pulse[i]` sets status flag i, read back at `rd_data[i]` after the next clock edge. Flag index 0 is the parallel-port clock error, 1 the receive alignment alarm, 2 the transmit alignment alarm and 3 the frame-sync alarm. The flag then stays set without further pulses until a write.
- R3: `irq` is high after a clock edge exactly when at least one status flag i is set while its mask `rd_data[4+i]` is 0. It changes at the same edge as the flags.
- R4: An event whose mask bit is 1 still sets its status flag, but it never drives `irq` high.
- R5: A write (`wr_en` high for one cycle) clears all status flags and `irq` at the next edge, for any written value.
- R6: A write loads the masks from `wr_data[7:4]` into `rd_data[7:4]`. `wr_data[3:0]` has no effect on any flag.
- R7: When an event pulse and a write fall in the same cycle, the event wins: that flag reads 1 after the edge, and `irq` follows it under the newly written mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 4 | One-cycle event pulses, one per alarm |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data, masks in bits 7:4 |
| rd_data | output | 8 | Register contents: masks 7:4, flags 3:0 |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench writes nonzero values into the low byte. A design that decoded those bits as flag sets, or as selective clears, would show wrong flags after the write. It drives an event and a write in the same cycle, with both an open mask and a newly closed mask. A design where the clear wins would drop the alarm, and one that used the old mask would raise or hold `irq` wrongly. It sets flags under masks and checks that `irq` stays low, which catches a mask that gates the flag itself or one that is ignored. It also fires all events at once with only some of them masked.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned ALARM_COUNT = 4;

  typedef enum logic [1:0] {
    ALM_PCLK_ERR  = 2'd0,
    ALM_RX_ALIGN  = 2'd1,
    ALM_TX_ALIGN  = 2'd2,
    ALM_FRAME_SYN = 2'd3
  } alarm_idx_e;
endpackage

// File: rtl/alarm_sticky_bit.sv
module alarm_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  // set has priority over clear
  always_comb nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/alarm_mask_reg.sv
module alarm_mask_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] val_i,
  output logic [N-1:0] nxt_o,
  output logic [N-1:0] q_o
);
  always_comb nxt_o = load_i ? val_i : q_o;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '1;
    else     q_o <= nxt_o;
  end

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(val_i)));
  assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_nxt_i,
  input  logic [N-1:0] mask_nxt_i,
  input  logic [N-1:0] flag_q_i,
  input  logic [N-1:0] mask_q_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flag_nxt_i & ~mask_nxt_i);
  end

  assert_irq_match_R3: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flag_q_i & ~mask_q_i));
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ((flag_q_i & ~mask_q_i) == '0) |-> !irq_o);
endmodule

// File: rtl/alarm_irq_reg.sv
module alarm_irq_reg #(
  parameter int unsigned N_ALARM = alarm_irq_pkg::ALARM_COUNT,
  localparam int unsigned RW = 2 * N_ALARM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_ALARM-1:0] ev_pulse,
  input  logic               wr_en,
  input  logic [RW-1:0]      wr_data,
  output logic [RW-1:0]      rd_data,
  output logic               irq
);
  logic [N_ALARM-1:0] flag_q, flag_nxt, mask_q, mask_nxt;

  for (genvar i = 0; i < N_ALARM; i++) begin : g_flag
    alarm_sticky_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (ev_pulse[i]),
      .clr_i (wr_en),
      .nxt_o (flag_nxt[i]),
      .q_o   (flag_q[i])
    );
  end

  alarm_mask_reg #(.N(N_ALARM)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .load_i (wr_en),
    .val_i  (wr_data[RW-1:N_ALARM]),
    .nxt_o  (mask_nxt),
    .q_o    (mask_q)
  );

  alarm_irq_gen #(.N(N_ALARM)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .flag_nxt_i (flag_nxt),
    .mask_nxt_i (mask_nxt),
    .flag_q_i   (flag_q),
    .mask_q_i   (mask_q),
    .irq_o      (irq)
  );

  assign rd_data = {mask_q, flag_q};

  // low data byte never sets a flag
  assert_low_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[N_ALARM-1:0] != '0) && (ev_pulse == '0))
      |=> (rd_data[N_ALARM-1:0] == '0));
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (ev_pulse != '0)) |=> ((rd_data[N_ALARM-1:0] & $past(ev_pulse)) == $past(ev_pulse)));
endmodule

// File: tb/alarm_irq_reg_tb.sv
module alarm_irq_reg_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ev_pulse = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_reg u_dut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [7:0] exp_rd, logic exp_irq);
    total++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      bad++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               req, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  // apply inputs for one edge, then return to idle at the next falling edge
  task automatic step(logic [3:0] ev, logic we, logic [7:0] wd);
    ev_pulse = ev; wr_en = we; wr_data = wd;
    @(negedge clk);
    ev_pulse = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    check("R1 reset", 8'hF0, 1'b0);
  endtask

  task automatic t_masked_set_hold;
    step(4'b0100, 1'b0, 8'h00);
    check("R2/R4 masked tx alarm", 8'hF4, 1'b0);
    for (int k = 0; k < 3; k++) step(4'b0000, 1'b0, 8'h00);
    check("R2 flag held", 8'hF4, 1'b0);
  endtask

  task automatic t_write_clear_open;
    step(4'b0000, 1'b1, 8'h0F);
    check("R5/R6 clear, low byte ignored", 8'h00, 1'b0);
    step(4'b0001, 1'b0, 8'h00);
    check("R3 unmasked pclk error", 8'h01, 1'b1);
    step(4'b1000, 1'b0, 8'h00);
    check("R2/R3 second flag", 8'h09, 1'b1);
    step(4'b0000, 1'b1, 8'hA5);
    check("R5/R6 clear and load mask A", 8'hA0, 1'b0);
  endtask

  task automatic t_partial_mask;
    step(4'b1000, 1'b0, 8'h00);
    check("R4 frame sync masked", 8'hA8, 1'b0);
    step(4'b0010, 1'b0, 8'h00);
    check("R4 rx align masked", 8'hAA, 1'b0);
    step(4'b0100, 1'b0, 8'h00);
    check("R3 tx align unmasked", 8'hAE, 1'b1);
  endtask

  task automatic t_collision;
    step(4'b0010, 1'b1, 8'h00);
    check("R7 event beats write, open mask", 8'h02, 1'b1);
    step(4'b0010, 1'b1, 8'h20);
    check("R7 event beats write, new mask", 8'h22, 1'b0);
    step(4'b1111, 1'b0, 8'h00);
    check("R3 all events one masked", 8'h2F, 1'b1);
    step(4'b0000, 1'b1, 8'hF3);
    check("R5 clear with all masks", 8'hF0, 1'b0);
    step(4'b1111, 1'b0, 8'h00);
    check("R4 all masked", 8'hFF, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masked_set_hold();
    t_write_clear_open();
    t_partial_mask();
    t_collision();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule